// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a 256 Hz time-base strobe into a periodic interrupt at one of six rates, from 256 Hz down to 1 Hz. A 3-bit rate field in a byte-wide control register picks the rate. Each period boundary sets a sticky event flag in the same register. Software clears the flag by writing a zero to it. The interrupt line is high while the flag is set and the rate field is nonzero.

Two write strobes share one data byte. The full-register strobe writes the rate field and the four general control bits, and it can clear the flag. The rate-only strobe changes the rate field and leaves every other bit as it is. When a write gives the rate field a new value, the period divider starts again from zero.

Internally a two-state divider machine (IDLE, COUNTING) counts strobes and emits one-cycle period events. A two-state flag machine (CLEAR, PENDING) holds the sticky flag.

Divider transitions:
- IDLE to COUNTING: a rate change to an active code.
- COUNTING to IDLE: a rate change to 0 or 7.
- COUNTING to COUNTING with the count zeroed: a rate change to another active code.

Flag transitions:
- CLEAR to PENDING: a period event.
- PENDING to CLEAR: a clear write in a cycle with no period event.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, `ctrl_q` reads 0x00 and `irq` is low.
- R2: `ctrl_q[6:4]` is the rate code. The period in 256 Hz strobes is:

  | Rate code | Period (strobes) | Rate |
  |---|---|---|
  | 1 | 1 | 256 Hz |
  | 2 | 4 | 64 Hz |
  | 3 | 16 | 16 Hz |
  | 4 | 64 | 4 Hz |
  | 5 | 128 | 2 Hz |
  | 6 | 256 | 1 Hz |

  The flag sets on the clock edge that samples the strobe ending a period.
- R3: Rate codes 0 and 7 produce no period events.
- R4: `ctrl_q[7]` is the event flag. A period event sets it, and it then stays set until it is cleared.
- R5: A `ctl_wr` write with `wdata[7]`=0 clears the flag. A `ctl_wr` write with `wdata[7]`=1 leaves the flag unchanged and can never set it.
- R6: If a period event and a clearing write happen in the same cycle, the flag ends up set.
- R7: `ctl_wr` loads `ctrl_q[6:4]` and `ctrl_q[3:0]` from `wdata`. `sel_wr` loads only `ctrl_q[6:4]` and keeps bit 7 and bits 3:0. If both strobes are high, `ctl_wr` takes effect.
- R8: A write that changes the rate code restarts the divider. A strobe in the same cycle as that write is not counted, so the first event comes one full new period later.
- R9: A write that leaves the rate code unchanged does not disturb the divider.
- R10: `irq` is high exactly when the flag is set and the rate code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_256 | input | 1 | One-cycle strobe at 256 Hz |
| ctl_wr | input | 1 | Full-register write strobe |
| sel_wr | input | 1 | Rate-field-only write strobe |
| wdata | input | 8 | Write data |
| ctrl_q | output | 8 | Control register: bit 7 flag, bits 6:4 rate, bits 3:0 general bits |
| irq | output | 1 | Periodic interrupt request |

## Verification
Each of the eight rate codes is programmed in turn from a vector table. The bench counts strobes to the first flag, clears the flag, and counts again. Together the two counts tell a correct period apart from an off-by-one count and from a divider that fails to reload after an event. Codes 0 and 7 must stay silent over more than the longest period.

Directed patterns then cover several separate cases:
- A mid-period switch to a shorter rate, which shows whether the restart happened.
- A same-value rewrite, which must not restart the divider.
- A strobe that coincides with a rate change, which must not be counted.
- A clear that collides with an event.
- The rate-only write, which must keep the other bits.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int RATE_W = 3;
    localparam int GEN_W  = 4;
    localparam int REG_W  = 1 + RATE_W + GEN_W;

    typedef enum logic [0:0] {DIV_IDLE, DIV_COUNTING} div_state_e;
    typedef enum logic [0:0] {FLG_CLEAR, FLG_PENDING} flg_state_e;

    // A rate code produces events only for codes 1..6.
    function automatic logic rate_active(input logic [RATE_W-1:0] code);
        return (code != '0) && (code != '1);
    endfunction

    // log2 of the period, counted in time-base strobes.
    function automatic logic [3:0] rate_shift(input logic [RATE_W-1:0] code);
        logic [3:0] s;
        unique case (code)
            3'd1:    s = 4'd0;
            3'd2:    s = 4'd2;
            3'd3:    s = 4'd4;
            3'd4:    s = 4'd6;
            3'd5:    s = 4'd7;
            3'd6:    s = 4'd8;
            default: s = 4'd0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/pit_rate_decode.sv
module pit_rate_decode
    import pit_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic [RATE_W-1:0] code,
    output logic [DIV_W-1:0]  term
);
    localparam int FULL_W = DIV_W + 1;

    logic [FULL_W-1:0] period;

    always_comb begin
        period = FULL_W'(1) << rate_shift(code);
        term   = DIV_W'(period - FULL_W'(1));
    end
endmodule

// File: rtl/pit_tick_divider.sv
module pit_tick_divider
    import pit_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic             restart_active,
    input  logic [DIV_W-1:0] term,
    output logic             evt
);
    div_state_e       st_q, st_nx;
    logic [DIV_W-1:0] cnt_q, cnt_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DIV_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    // Next state and count
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        unique case (st_q)
            DIV_IDLE: begin
                if (restart && restart_active) st_nx = DIV_COUNTING;
            end
            DIV_COUNTING: begin
                if (restart) begin
                    st_nx = restart_active ? DIV_COUNTING : DIV_IDLE;
                end else if (tick) begin
                    cnt_nx = (cnt_q == term) ? '0 : cnt_q + DIV_W'(1);
                end
            end
            default: st_nx = DIV_IDLE;
        endcase
        if (restart) cnt_nx = '0;
    end

    // Outputs
    always_comb begin
        evt = 1'b0;
        unique case (st_q)
            DIV_IDLE:     evt = 1'b0;
            DIV_COUNTING: evt = tick && !restart && (cnt_q == term);
            default:      evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/pit_flag_fsm.sv
module pit_flag_fsm
    import pit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    flg_state_e st_q, st_nx;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLG_CLEAR;
        else        st_q <= st_nx;
    end

    // Next state: an event beats a clear in the same cycle
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FLG_CLEAR:   if (evt) st_nx = FLG_PENDING;
            FLG_PENDING: if (clr && !evt) st_nx = FLG_CLEAR;
            default:     st_nx = FLG_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            FLG_PENDING: flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pit_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_256,
    input  logic             ctl_wr,
    input  logic             sel_wr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             irq
);
    localparam int RATE_LO = GEN_W;
    localparam int RATE_HI = GEN_W + RATE_W - 1;

    logic [RATE_W-1:0] rate_q;
    logic [GEN_W-1:0]  gen_q;
    logic [RATE_W-1:0] rate_new;
    logic [DIV_W-1:0]  term;
    logic              any_wr, restart, clr, evt_w, flag;

    assign any_wr   = ctl_wr || sel_wr;
    assign rate_new = wdata[RATE_HI:RATE_LO];
    assign restart  = any_wr && (rate_new != rate_q);
    assign clr      = ctl_wr && !wdata[REG_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            gen_q  <= '0;
        end else begin
            if (any_wr) rate_q <= rate_new;
            if (ctl_wr) gen_q  <= wdata[GEN_W-1:0];
        end
    end

    pit_rate_decode #(.DIV_W(DIV_W)) u_dec (
        .code (rate_q),
        .term (term)
    );

    pit_tick_divider #(.DIV_W(DIV_W)) u_div (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick_256),
        .restart        (restart),
        .restart_active (rate_active(rate_new)),
        .term           (term),
        .evt            (evt_w)
    );

    pit_flag_fsm u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt_w),
        .clr   (clr),
        .flag  (flag)
    );

    assign ctrl_q = {flag, rate_q, gen_q};
    assign irq    = flag && (rate_q != '0);
endmodule

// File: rtl/pit_checker.sv
module pit_checker
    import pit_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick_256,
    input logic             ctl_wr,
    input logic             sel_wr,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] ctrl_q,
    input logic             evt
);
    AST_EVT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> tick_256); // R2
    AST_OFF_CODES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6:4] == 3'd0 || ctrl_q[6:4] == 3'd7) |-> !evt); // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && !(ctl_wr && !wdata[7])) |=> ctrl_q[7]); // R4
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !wdata[7] && !evt) |=> !ctrl_q[7]); // R5
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[7] && !evt) |=> !ctrl_q[7]); // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> ctrl_q[7]); // R6
    AST_SELWR_KEEPS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && !ctl_wr) |=> $stable(ctrl_q[3:0])); // R7
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_wr || sel_wr) && (wdata[6:4] != ctrl_q[6:4])) |-> !evt); // R8
endmodule

bind periodic_irq_gen pit_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_256 (tick_256),
    .ctl_wr   (ctl_wr),
    .sel_wr   (sel_wr),
    .wdata    (wdata),
    .ctrl_q   (ctrl_q),
    .evt      (evt_w)
);

// File: tb/sim_periodic_irq_gen.sv
module sim_periodic_irq_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_256 = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       sel_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] ctrl_q;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    periodic_irq_gen u0 (
        .clk(clk), .rst_n(rst_n), .tick_256(tick_256), .ctl_wr(ctl_wr),
        .sel_wr(sel_wr), .wdata(wdata), .ctrl_q(ctrl_q), .irq(irq)
    );

    // {rate code, expected period in strobes; 0 means silent}
    localparam logic [11:0] VEC [8] = '{
        {3'd1, 9'd1}, {3'd2, 9'd4}, {3'd3, 9'd16}, {3'd4, 9'd64},
        {3'd5, 9'd128}, {3'd6, 9'd256}, {3'd7, 9'd0}, {3'd0, 9'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick_once();
        @(negedge clk) tick_256 = 1'b1;
        @(negedge clk) tick_256 = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic wr_ctl(input logic [7:0] d, input logic with_tick);
        @(negedge clk) begin ctl_wr = 1'b1; wdata = d; tick_256 = with_tick; end
        @(negedge clk) begin ctl_wr = 1'b0; tick_256 = 1'b0; end
    endtask

    task automatic wr_sel(input logic [7:0] d, input logic with_tick);
        @(negedge clk) begin sel_wr = 1'b1; wdata = d; tick_256 = with_tick; end
        @(negedge clk) begin sel_wr = 1'b0; tick_256 = 1'b0; end
    endtask

    task automatic count_to_flag(output int n);
        n = 0;
        for (int k = 1; k <= 300; k++) begin
            tick_once();
            if (ctrl_q[7]) begin n = k; break; end
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        logic [2:0] code;
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ctrl after reset", int'(ctrl_q), 0);
        check("R1 irq after reset", int'(irq), 0);

        // Table walk: R2 periods, R3 silent codes, R10 irq
        for (int v = 0; v < 8; v++) begin
            code = VEC[v][11:9];
            exp  = int'(VEC[v][8:0]);
            wr_ctl({1'b0, code, 4'h0}, 1'b0);
            count_to_flag(n);
            check(exp == 0 ? "R3 silent code" : "R2 first period", n, exp);
            if (exp != 0) begin
                check("R10 irq with flag", int'(irq), 1);
                wr_ctl({1'b0, code, 4'h0}, 1'b0);
                count_to_flag(n);
                check("R2 second period", n, exp);
            end
        end

        // R8: mid-period change to shorter rate restarts
        wr_ctl(8'h30, 1'b0);
        ticks(10);
        wr_sel(8'h20, 1'b0);
        count_to_flag(n);
        check("R8 restart on change", n, 4);

        // R8: strobe in the write cycle is not counted
        wr_ctl(8'h10, 1'b0);
        wr_ctl(8'h20, 1'b1);
        count_to_flag(n);
        check("R8 write-cycle strobe ignored", n, 4);

        // R9: same-value rewrite keeps the count
        wr_ctl(8'h30, 1'b0);
        ticks(10);
        wr_sel(8'h30, 1'b0);
        count_to_flag(n);
        check("R9 no restart on same code", n, 6);

        // R4: flag stays set over further events and idle time
        ticks(20);
        check("R4 flag sticky", int'(ctrl_q[7]), 1);

        // R5: writing 1 to the flag leaves it set
        wr_ctl(8'hB0, 1'b0);
        check("R5 write one keeps flag", int'(ctrl_q[7]), 1);

        // R7 / R10: rate-only write to 0 keeps flag, irq drops
        wr_sel(8'h0F, 1'b0);
        check("R7 sel_wr keeps flag and gen bits", int'(ctrl_q), 8'h80);
        check("R10 irq low with code 0", int'(irq), 0);

        // R5: clear, then writing 1 cannot set it
        wr_ctl(8'h0A, 1'b0);
        check("R5 clear", int'(ctrl_q[7]), 0);
        wr_ctl(8'h8A, 1'b0);
        check("R5 write one cannot set", int'(ctrl_q), 8'h0A);

        // R7: rate-only write changes bits 6:4 only
        wr_sel(8'hD5, 1'b0);
        check("R7 sel_wr field only", int'(ctrl_q), 8'h5A);

        // R7: both strobes, ctl_wr wins
        @(negedge clk) begin ctl_wr = 1'b1; sel_wr = 1'b1; wdata = 8'h23; end
        @(negedge clk) begin ctl_wr = 1'b0; sel_wr = 1'b0; end
        check("R7 both strobes", int'(ctrl_q), 8'h23);

        // R6: clear colliding with an event leaves flag set
        wr_ctl(8'h10, 1'b0);
        tick_once();
        wr_ctl(8'h10, 1'b1);
        check("R6 event beats clear", int'(ctrl_q[7]), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule